// File: doc/BRIEF.md
# Parallel NOR Flash Write-Command Controller

This block models the write-command state machine of a parallel NOR flash in front of a small sectored word array. The host issues write cycles: an address, a data word and a one-cycle write strobe. The decoder walks these cycles through the unlock prefix and turns them into a word program, a sector erase, a chip erase, an unlock-bypass session, a suspend or a resume. Program and erase operations run for a parameterised number of clock cycles. While one runs, the ready output is low and reads return a status word in place of array data.

The array holds `2**ADDR_W` words of `DATA_W` bits, split into `2**SECT_W` equal sectors. The sector number is the top `SECT_W` bits of the word address. Each sector has a protect input. An erase can be paused so that other sectors can be read or programmed. A program can be paused so that other sectors can be read.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: A word program is four writes: data AA at address 555, then 55 at 2AA, then A0 at 555, then the program data at the target address. Command addresses are compared on the low `ADDR_W` bits, so with the default 8-bit address they are 0x55 and 0xAA. Command codes sit in data bits 7:0.
- R2: Programming can only clear bits. The stored word becomes the old word ANDed with the written word.
- R3: `ready_o` falls in the cycle after the write that starts an operation. It stays low for exactly `PROG_CYC` cycles for a program and `ERASE_CYC` cycles for an erase. It never falls without a write.
- R4: `rdata_o` is registered and updates one cycle after `re_i`. While busy, a read returns a status word. Bit 7 is the complement of bit 7 of the word being programmed, or 0 when no program is pending. Bit 6 flips on every status read. All other bits are 0.
- R5: A sector erase is AA@555, 55@2AA, 80@555, AA@555, 55@2AA, then 30 at any address inside the sector. Every word of that sector becomes all ones and all other sectors keep their contents.
- R6: A chip erase uses the same five-write prefix followed by 10 at 555. It sets every word of every unprotected sector to all ones.
- R7: When `sect_prot_i[s]` is 1, a program or sector erase aimed at sector s is dropped: `ready_o` stays high and the array is unchanged. A chip erase skips that sector.
- R8: A write that does not match the next expected step returns the decoder to the read state without starting anything.
- R9: In unlock bypass, entered with AA@555, 55@2AA, 20@555, a program is two writes: A0 at any address, then the data at the target. Other writes leave bypass active. 90 followed by 00 exits to the normal read state.
- R10: Writing B0 during a sector erase suspends it and raises `ready_o`. Other sectors can then be read and programmed. Reads of the erasing sector return status. Programs to that sector and any new erase are dropped. Writing 30 resumes the erase, which then completes.
- R11: Writing B0 during a program suspends it and raises `ready_o`. Other sectors read array data. Every write except 30 is dropped. Writing 30 resumes and completes the program.
- R12: While busy, every write other than B0 is ignored, and B0 is ignored during a chip erase.
- R13: After reset every word reads as all ones, `ready_o` is high and the decoder is in the read state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Write strobe, one cycle per write |
| re_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Word address for reads and writes |
| wdata_i | input | DATA_W | Write data or command code |
| sect_prot_i | input | 2**SECT_W | Per-sector protect bits |
| rdata_o | output | DATA_W | Read data or status word |
| ready_o | output | 1 | High when no program or erase is running |

## Verification
The hardest state to reach is a program that starts inside a suspended erase. Reaching it takes a complete six-write erase sequence, a suspend written while the erase timer is still counting, a full unlock-and-program sequence aimed at another sector, and then a resume. The bench chains these writes back to back so that the suspend lands early in the erase. While suspended, it also attempts a second erase and a program into the suspended sector. Afterwards it sweeps every word against a bench-side model, which shows that only the intended sectors changed.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  typedef enum logic [3:0] {
    DS_READ, DS_UNL1, DS_UNL2, DS_ERS3, DS_ERS4, DS_ERS5,
    DS_PGM, DS_BYP, DS_BYP_PGM, DS_BYP_EXIT
  } dec_state_e;

  localparam logic [7:0] CMD_UNL_A   = 8'hAA;
  localparam logic [7:0] CMD_UNL_B   = 8'h55;
  localparam logic [7:0] CMD_PROG    = 8'hA0;
  localparam logic [7:0] CMD_ERASE   = 8'h80;
  localparam logic [7:0] CMD_SECT    = 8'h30;
  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_BYP_IN  = 8'h20;
  localparam logic [7:0] CMD_BYP_X1  = 8'h90;
  localparam logic [7:0] CMD_BYP_X2  = 8'h00;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_RESUME  = 8'h30;
endpackage

// File: rtl/nfc_decoder.sv
module nfc_decoder
  import nfc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        cmd_i,
  input  logic              ers_lock_i,
  output logic              pgm_req_o,
  output logic              ers_req_o,
  output logic              chip_req_o,
  output logic              rd_state_o
);
  localparam logic [ADDR_W-1:0] ADR_HI = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] ADR_LO = ADDR_W'(12'h2AA);

  dec_state_e st_q, st_d;
  logic at_hi, at_lo;

  assign at_hi = (addr_i == ADR_HI);
  assign at_lo = (addr_i == ADR_LO);

  always_comb begin
    st_d       = st_q;
    pgm_req_o  = 1'b0;
    ers_req_o  = 1'b0;
    chip_req_o = 1'b0;
    if (step_i) begin
      st_d = DS_READ;
      unique case (st_q)
        DS_READ: if (at_hi && cmd_i == CMD_UNL_A) st_d = DS_UNL1;
        DS_UNL1: if (at_lo && cmd_i == CMD_UNL_B) st_d = DS_UNL2;
        DS_UNL2: begin
          if (at_hi && cmd_i == CMD_PROG) st_d = DS_PGM;
          else if (at_hi && cmd_i == CMD_ERASE && !ers_lock_i) st_d = DS_ERS3;
          else if (at_hi && cmd_i == CMD_BYP_IN) st_d = DS_BYP;
        end
        DS_ERS3: if (at_hi && cmd_i == CMD_UNL_A) st_d = DS_ERS4;
        DS_ERS4: if (at_lo && cmd_i == CMD_UNL_B) st_d = DS_ERS5;
        DS_ERS5: begin
          if (cmd_i == CMD_SECT) ers_req_o = 1'b1;
          else if (at_hi && cmd_i == CMD_CHIP) chip_req_o = 1'b1;
        end
        DS_PGM: pgm_req_o = 1'b1;
        DS_BYP: begin
          st_d = DS_BYP;
          if (cmd_i == CMD_PROG) st_d = DS_BYP_PGM;
          else if (cmd_i == CMD_BYP_X1) st_d = DS_BYP_EXIT;
        end
        DS_BYP_PGM: begin
          pgm_req_o = 1'b1;
          st_d      = DS_BYP;
        end
        DS_BYP_EXIT: st_d = (cmd_i == CMD_BYP_X2) ? DS_READ : DS_BYP;
        default: st_d = DS_READ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= DS_READ;
    else         st_q <= st_d;

  assign rd_state_o = (st_q == DS_READ) || (st_q == DS_BYP);
endmodule

// File: rtl/nfc_engine.sv
module nfc_engine
  import nfc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int SECT_W    = 2,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 24,
  localparam int NSECT    = 1 << SECT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [7:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pgm_req_i,
  input  logic              ers_req_i,
  input  logic              chip_req_i,
  input  logic              rd_state_i,
  input  logic [NSECT-1:0]  prot_i,
  output logic              dec_en_o,
  output logic              busy_o,
  output logic              pgm_run_o,
  output logic              ers_run_o,
  output logic              pgm_done_o,
  output logic [ADDR_W-1:0] pgm_addr_o,
  output logic [DATA_W-1:0] pgm_data_o,
  output logic              ers_done_o,
  output logic [NSECT-1:0]  ers_mask_o,
  output logic              pgm_act_o,
  output logic              ers_act_o,
  output logic [SECT_W-1:0] ers_sect_o
);
  localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic              pgm_act_q, pgm_sus_q, ers_act_q, ers_sus_q, ers_chip_q;
  logic [CNT_W-1:0]  pgm_cnt_q, ers_cnt_q;
  logic [ADDR_W-1:0] pgm_addr_q;
  logic [DATA_W-1:0] pgm_data_q;
  logic [SECT_W-1:0] ers_sect_q, sect_in;
  logic              sus_hit, res_hit, pgm_ok, ers_ok, chip_ok;
  logic [NSECT-1:0]  sect_oh;

  assign sect_in    = addr_i[ADDR_W-1 -: SECT_W];
  assign pgm_run_o  = pgm_act_q & ~pgm_sus_q;
  assign ers_run_o  = ers_act_q & ~ers_sus_q;
  assign busy_o     = pgm_run_o | ers_run_o;
  assign pgm_done_o = pgm_run_o & (pgm_cnt_q == CNT_W'(1));
  assign ers_done_o = ers_run_o & (ers_cnt_q == CNT_W'(1));

  assign sus_hit  = we_i & busy_o & (cmd_i == CMD_SUSPEND);
  assign res_hit  = we_i & ~busy_o & rd_state_i & (cmd_i == CMD_RESUME) & (pgm_sus_q | ers_sus_q);
  assign dec_en_o = we_i & ~busy_o & ~pgm_sus_q & ~res_hit;

  // targets inside a suspended erase or a protected sector are dropped
  assign pgm_ok  = pgm_req_i & ~prot_i[sect_in] & ~(ers_act_q & (sect_in == ers_sect_q));
  assign ers_ok  = ers_req_i & ~prot_i[sect_in] & ~ers_act_q;
  assign chip_ok = chip_req_i & ~ers_act_q;

  always_comb begin
    sect_oh             = '0;
    sect_oh[ers_sect_q] = 1'b1;
  end
  assign ers_mask_o = ers_done_o ? (ers_chip_q ? ~prot_i : sect_oh) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pgm_act_q  <= 1'b0;
      pgm_sus_q  <= 1'b0;
      pgm_cnt_q  <= '0;
      pgm_addr_q <= '0;
      pgm_data_q <= '0;
    end else if (pgm_ok) begin
      pgm_act_q  <= 1'b1;
      pgm_sus_q  <= 1'b0;
      pgm_cnt_q  <= CNT_W'(PROG_CYC);
      pgm_addr_q <= addr_i;
      pgm_data_q <= wdata_i;
    end else if (pgm_done_o) begin
      pgm_act_q <= 1'b0;
    end else if (pgm_run_o) begin
      if (sus_hit) pgm_sus_q <= 1'b1;
      else         pgm_cnt_q <= pgm_cnt_q - CNT_W'(1);
    end else if (res_hit && pgm_sus_q) begin
      pgm_sus_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ers_act_q  <= 1'b0;
      ers_sus_q  <= 1'b0;
      ers_chip_q <= 1'b0;
      ers_cnt_q  <= '0;
      ers_sect_q <= '0;
    end else if (ers_ok || chip_ok) begin
      ers_act_q  <= 1'b1;
      ers_sus_q  <= 1'b0;
      ers_chip_q <= chip_ok;
      ers_cnt_q  <= CNT_W'(ERASE_CYC);
      ers_sect_q <= sect_in;
    end else if (ers_done_o) begin
      ers_act_q <= 1'b0;
    end else if (ers_run_o) begin
      if (sus_hit && !ers_chip_q) ers_sus_q <= 1'b1;
      else                        ers_cnt_q <= ers_cnt_q - CNT_W'(1);
    end else if (res_hit && !pgm_sus_q && ers_sus_q) begin
      ers_sus_q <= 1'b0;
    end
  end

  assign pgm_addr_o = pgm_addr_q;
  assign pgm_data_o = pgm_data_q;
  assign pgm_act_o  = pgm_act_q;
  assign ers_act_o  = ers_act_q;
  assign ers_sect_o = ers_sect_q;
endmodule

// File: rtl/nfc_array.sv
module nfc_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int SECT_W = 2,
  localparam int NSECT = 1 << SECT_W,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int OFF_W = ADDR_W - SECT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pgm_we_i,
  input  logic [ADDR_W-1:0] pgm_addr_i,
  input  logic [DATA_W-1:0] pgm_data_i,
  input  logic [NSECT-1:0]  ers_mask_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              stat_sel_i,
  input  logic              poll_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] stat_w;
  logic              tog_q;

  always_comb begin
    stat_w    = '0;
    stat_w[7] = poll_i;
    stat_w[6] = tog_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
      rdata_o <= '0;
      tog_q   <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (ers_mask_i[SECT_W'(i >> OFF_W)]) mem_q[i] <= '1;
      if (pgm_we_i) mem_q[pgm_addr_i] <= mem_q[pgm_addr_i] & pgm_data_i;
      if (re_i) begin
        if (stat_sel_i) begin
          rdata_o <= stat_w;
          tog_q   <= ~tog_q;
        end else begin
          rdata_o <= mem_q[addr_i];
        end
      end
    end
  end
endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import nfc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int SECT_W    = 2,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 24
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic                   re_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic [(1<<SECT_W)-1:0] sect_prot_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic                   ready_o
);
  localparam int NSECT = 1 << SECT_W;

  logic              dec_en, pgm_req, ers_req, chip_req, rd_state;
  logic              busy, pgm_run, ers_run, pgm_done, ers_done, pgm_act, ers_act;
  logic [ADDR_W-1:0] pgm_addr;
  logic [DATA_W-1:0] pgm_data;
  logic [NSECT-1:0]  ers_mask;
  logic [SECT_W-1:0] ers_sect, rd_sect, pgm_sect;
  logic              stat_sel, poll;

  nfc_decoder #(.ADDR_W(ADDR_W)) u_dec (
    .clk_i, .rst_ni,
    .step_i     (dec_en),
    .addr_i,
    .cmd_i      (wdata_i[7:0]),
    .ers_lock_i (ers_act),
    .pgm_req_o  (pgm_req),
    .ers_req_o  (ers_req),
    .chip_req_o (chip_req),
    .rd_state_o (rd_state)
  );

  nfc_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_eng (
    .clk_i, .rst_ni, .we_i,
    .cmd_i      (wdata_i[7:0]),
    .addr_i, .wdata_i,
    .pgm_req_i  (pgm_req),
    .ers_req_i  (ers_req),
    .chip_req_i (chip_req),
    .rd_state_i (rd_state),
    .prot_i     (sect_prot_i),
    .dec_en_o   (dec_en),
    .busy_o     (busy),
    .pgm_run_o  (pgm_run),
    .ers_run_o  (ers_run),
    .pgm_done_o (pgm_done),
    .pgm_addr_o (pgm_addr),
    .pgm_data_o (pgm_data),
    .ers_done_o (ers_done),
    .ers_mask_o (ers_mask),
    .pgm_act_o  (pgm_act),
    .ers_act_o  (ers_act),
    .ers_sect_o (ers_sect)
  );

  assign rd_sect  = addr_i[ADDR_W-1 -: SECT_W];
  assign pgm_sect = pgm_addr[ADDR_W-1 -: SECT_W];
  // suspended targets keep answering with status
  assign stat_sel = busy | (ers_act & (rd_sect == ers_sect)) | (pgm_act & (rd_sect == pgm_sect));
  assign poll     = pgm_act & ~pgm_data[7];

  nfc_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_arr (
    .clk_i, .rst_ni,
    .pgm_we_i   (pgm_done),
    .pgm_addr_i (pgm_addr),
    .pgm_data_i (pgm_data),
    .ers_mask_i (ers_mask),
    .re_i, .addr_i,
    .stat_sel_i (stat_sel),
    .poll_i     (poll),
    .rdata_o
  );

  assign ready_o = ~busy;
endmodule

// File: rtl/nor_cmd_ctrl_chk.sv
module nor_cmd_ctrl_chk #(
  parameter int DATA_W = 16,
  parameter int SECT_W = 2,
  localparam int NSECT = 1 << SECT_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic              re_i,
  input logic              ready_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic [NSECT-1:0]  prot_i,
  input logic              pgm_run,
  input logic              ers_run,
  input logic              pgm_done,
  input logic              ers_done,
  input logic [NSECT-1:0]  ers_mask,
  input logic [SECT_W-1:0] pgm_sect,
  input logic              pgm_d7
);
  logic stat_rd_d, have_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_rd_d <= 1'b0;
      have_q    <= 1'b0;
      last_q    <= 1'b0;
    end else begin
      stat_rd_d <= re_i & ~ready_o;
      if (re_i && ready_o) have_q <= 1'b0;
      else if (stat_rd_d) begin
        have_q <= 1'b1;
        last_q <= rdata_o[6];
      end
    end
  end

  assert_ready_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !we_i) |=> ready_o);
  assert_ready_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(pgm_done || ers_done || we_i));
  assert_toggle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_d && have_q) |-> (rdata_o[6] != last_q));
  assert_poll_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !ready_o && pgm_run) |=> (rdata_o[7] == ~$past(pgm_d7)));
  assert_one_op_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pgm_run, ers_run}));
  assert_prot_erase_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ers_done |-> ((ers_mask & prot_i) == '0));
  assert_prot_pgm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgm_done |-> !prot_i[pgm_sect]);
endmodule

bind nor_cmd_ctrl nor_cmd_ctrl_chk #(.DATA_W(DATA_W), .SECT_W(SECT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .re_i     (re_i),
  .ready_o  (ready_o),
  .rdata_o  (rdata_o),
  .prot_i   (sect_prot_i),
  .pgm_run  (pgm_run),
  .ers_run  (ers_run),
  .pgm_done (pgm_done),
  .ers_done (ers_done),
  .ers_mask (ers_mask),
  .pgm_sect (pgm_sect),
  .pgm_d7   (pgm_data[7])
);

// File: tb/tb_nor_cmd_ctrl.sv
module tb_nor_cmd_ctrl;
  localparam int AW = 8, DW = 16, SW = 2, PC = 8, EC = 24;
  localparam int DEPTH = 1 << AW, WPS = 1 << (AW - SW);
  localparam logic [AW-1:0] AH = 8'h55, AL = 8'hAA;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, re = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic [3:0] prot = '0;
  logic ready;
  int checks = 0, fails = 0;
  bit finished = 0;
  logic [DW-1:0] model [DEPTH];

  always #4 clk = ~clk;

  nor_cmd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SECT_W(SW), .PROG_CYC(PC), .ERASE_CYC(EC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .re_i(re), .addr_i(addr), .wdata_i(wdata),
    .sect_prot_i(prot), .rdata_o(rdata), .ready_o(ready));

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic unl();
    wr(AH, 16'h00AA); wr(AL, 16'h0055);
  endtask

  task automatic prog(logic [AW-1:0] a, logic [DW-1:0] d);
    unl(); wr(AH, 16'h00A0); wr(a, d);
  endtask

  task automatic ers_pre();
    unl(); wr(AH, 16'h0080); unl();
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (!ready && n < 2000) begin n++; @(negedge clk); end
  endtask

  task automatic model_erase(int s);
    for (int i = s * WPS; i < (s + 1) * WPS; i++) model[i] = '1;
  endtask

  task automatic sweep(string req);
    logic [DW-1:0] v;
    for (int i = 0; i < DEPTH; i++) begin
      rd(AW'(i), v);
      chk(req, v, model[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v, s1, s2;
    int n;
    for (int i = 0; i < DEPTH; i++) model[i] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    chk("R13 ready", DW'(ready), 16'h1);
    rd(8'h00, v); chk("R13 word0", v, 16'hFFFF);
    rd(8'hFF, v); chk("R13 wordFF", v, 16'hFFFF);

    // R1 R3 four-write program, exact busy length
    prog(8'h10, 16'h1234); wait_rdy(n);
    chk("R3 prog busy", DW'(n), DW'(PC));
    model[16] = 16'h1234;
    rd(8'h10, v); chk("R1 prog", v, 16'h1234);

    // R2 AND semantics
    prog(8'h10, 16'hFF0F); wait_rdy(n);
    model[16] = 16'h1204;
    rd(8'h10, v); chk("R2 and", v, 16'h1204);

    // R4 status while programming
    prog(8'h90, 16'h0055);
    rd(8'h00, s1); rd(8'h00, s2);
    chk("R4 poll bit7", DW'(s1[7]), 16'h1);
    chk("R4 other bits", s1 & 16'hFF3F, 16'h0);
    chk("R4 toggle", DW'(s1[6] ^ s2[6]), 16'h1);
    wait_rdy(n); model[8'h90] = 16'h0055;

    // R12 writes during busy ignored
    prog(8'hC0, 16'hABCD);
    wr(AH, 16'h00AA);
    wait_rdy(n); model[8'hC0] = 16'hABCD;
    wr(AL, 16'h0055); wr(AH, 16'h00A0); wr(8'h22, 16'h0000);
    chk("R12 ready", DW'(ready), 16'h1);
    rd(8'h22, v); chk("R12 busy write", v, 16'hFFFF);

    // R8 broken sequences
    wr(AH, 16'h00AA); wr(8'h00, 16'h0055); wr(AH, 16'h00A0); wr(8'h23, 16'h0000);
    chk("R8 ready a", DW'(ready), 16'h1);
    rd(8'h23, v); chk("R8 bad addr", v, 16'hFFFF);
    unl(); wr(AH, 16'h0077); wr(8'h24, 16'h0000);
    rd(8'h24, v); chk("R8 bad cmd", v, 16'hFFFF);
    unl(); wr(AH, 16'h0080); wr(AH, 16'h00AA); wr(8'h00, 16'h0055); wr(8'h40, 16'h0030);
    chk("R8 ready erase", DW'(ready), 16'h1);

    // R5 sector erase keeps others
    prog(8'h45, 16'h0F0F); wait_rdy(n); model[8'h45] = 16'h0F0F;
    prog(8'h7F, 16'h1111); wait_rdy(n); model[8'h7F] = 16'h1111;
    prog(8'h3F, 16'h2222); wait_rdy(n); model[8'h3F] = 16'h2222;
    prog(8'h80, 16'h3333); wait_rdy(n); model[8'h80] = 16'h3333;
    ers_pre(); wr(8'h47, 16'h0030);
    rd(8'h00, v); chk("R4 erase poll", v & 16'hFFBF, 16'h0);
    wait_rdy(n);
    chk("R3 erase busy", DW'(n), DW'(EC - 2));
    model_erase(1);
    sweep("R5 sector erase");

    // R7 protection
    prot = 4'b0100;
    prog(8'h85, 16'h0000);
    chk("R7 prog ready", DW'(ready), 16'h1);
    rd(8'h85, v); chk("R7 prog ignored", v, 16'hFFFF);
    ers_pre(); wr(8'h80, 16'h0030);
    chk("R7 erase ready", DW'(ready), 16'h1);
    rd(8'h80, v); chk("R7 erase ignored", v, 16'h3333);

    // R6 chip erase skips protected sector, R12 suspend ignored
    ers_pre(); wr(AH, 16'h0010);
    wr(8'h00, 16'h00B0);
    chk("R12 chip no suspend", DW'(ready), 16'h0);
    wait_rdy(n);
    model_erase(0); model_erase(1); model_erase(3);
    sweep("R6 chip erase");
    prot = '0;

    // R9 unlock bypass
    unl(); wr(AH, 16'h0020);
    for (int k = 0; k < 8; k++) begin
      logic [DW-1:0] d;
      d = DW'(16'hF0F0 ^ (k * 16'h0111));
      wr(8'h00, 16'h00A0); wr(AW'(8'h08 + k), d); wait_rdy(n);
      model[8'h08 + k] = d;
    end
    wr(8'h00, 16'h0012);
    wr(8'h00, 16'h00A0); wr(8'h30, 16'h5A5A); wait_rdy(n); model[8'h30] = 16'h5A5A;
    wr(8'h00, 16'h0090); wr(8'h00, 16'h0000);
    wr(8'h00, 16'h00A0); wr(8'h31, 16'h0000);
    chk("R9 exit ready", DW'(ready), 16'h1);
    sweep("R9 bypass");

    // R10 erase suspend with nested program
    prog(8'h50, 16'h1111); wait_rdy(n); model[8'h50] = 16'h1111;
    prog(8'hC8, 16'h7777); wait_rdy(n); model[8'hC8] = 16'h7777;
    ers_pre(); wr(8'h40, 16'h0030);
    wr(8'h00, 16'h00B0);
    chk("R10 suspended ready", DW'(ready), 16'h1);
    rd(8'h10, v); chk("R10 read other", v, model[16]);
    rd(8'h50, v); chk("R10 status on erasing", v & 16'hFFBF, 16'h0);
    prog(8'hC5, 16'h0F0F); wait_rdy(n); model[8'hC5] = 16'h0F0F;
    rd(8'hC5, v); chk("R10 prog other", v, 16'h0F0F);
    prog(8'h51, 16'h0000);
    chk("R10 prog same ignored", DW'(ready), 16'h1);
    ers_pre(); wr(8'hC0, 16'h0030);
    chk("R10 erase ignored", DW'(ready), 16'h1);
    wr(8'h00, 16'h0030);
    chk("R10 resumed busy", DW'(ready), 16'h0);
    wait_rdy(n);
    model_erase(1);
    sweep("R10 after resume");

    // R11 program suspend
    prog(8'h12, 16'h0070);
    wr(8'h00, 16'h00B0);
    chk("R11 suspended ready", DW'(ready), 16'h1);
    rd(8'hC5, v); chk("R11 read other", v, 16'h0F0F);
    rd(8'h12, v); chk("R11 status bit7", DW'(v[7]), 16'h1);
    prog(8'hC6, 16'h0000);
    chk("R11 write ignored ready", DW'(ready), 16'h1);
    rd(8'hC6, v); chk("R11 write ignored", v, 16'hFFFF);
    wr(8'h00, 16'h0030);
    chk("R11 resumed busy", DW'(ready), 16'h0);
    wait_rdy(n); model[8'h12] = 16'h0070;
    rd(8'h12, v); chk("R11 completed", v, 16'h0070);

    sweep("R5 final");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule